// File: doc/BRIEF.md
# Charger protection fault supervisor

This block supervises the protection side of a single-cell charger. Every clock it takes digitized readings of the bus voltage, the battery voltage and the battery regulation setpoint, all in millivolts. It also takes a system over-current comparator flag and an input-present flag. From these it decides three things: whether boost switching may run, whether charging is allowed, and whether the battery switch stays closed. It also picks the charge-current limit that applies.

Boost over-voltage and battery over-voltage each set their own sticky bit in an 8-bit fault register. A host read clears the register. Whenever a bit sets, the block drives an active-low interrupt pulse of fixed length. After a system over-current, the battery switch stays latched open. A host action cannot release it. Only a fresh source insertion on the bus input does.

The block is built from three state machines:
- The boost controller has the states BST_OFF, BST_RUN and BST_TRIP. A boost-enable strobe moves BST_OFF to BST_RUN and also BST_TRIP to BST_RUN. Bus over-voltage while in BST_RUN moves to BST_TRIP.
- The battery-switch latch has the states SW_CLOSED and SW_LATCHED. Over-current moves SW_CLOSED to SW_LATCHED. An insertion edge with no over-current moves SW_LATCHED back to SW_CLOSED.
- The interrupt generator has the states IRQ_IDLE and IRQ_PULSE. A new fault bit moves IRQ_IDLE to IRQ_PULSE and also restarts IRQ_PULSE. When the count is spent, IRQ_PULSE returns to IRQ_IDLE.

Top module: `chg_fault_sup`

## Requirements
- R1: After reset the fault register reads 0, boost_on is 0, chg_en is 1, batsw_on is 1 and irq_n is 1.
- R2: A boost_en_stb sampled at a clock edge sets boost_on after that edge. While boost runs, a vbus_mv above 5300 clears boost_on at the next edge. A value of exactly 5300 does not.
- R3: After a boost over-voltage trip, boost_on stays 0 whatever vbus_mv does, until a fresh boost_en_stb is seen.
- R4: A boost over-voltage trip sets fault_reg bit 6 at the same edge at which boost_on falls.
- R5: chg_en is 0 in the same cycle, with no clock edge in between, whenever vbat_mv > vreg_mv + floor(vreg_mv*41/1024). Otherwise it is 1.
- R6: A battery over-voltage sampled at an edge sets fault_reg bit 5 at that edge.
- R7: ilim_ma is 100 in the same cycle whenever vbat_mv < 2000. Otherwise it equals ilim_prog_ma.
- R8: ocp_flag sampled high at an edge clears batsw_on at that edge. It stays 0 while src_present holds a steady level.
- R9: A 0-to-1 change of src_present closes the battery switch again, with batsw_on high after the third edge. This happens only if ocp_flag is low on that cycle. A src_present level that stays high never releases the latch.
- R10: Fault bits are sticky. The edge that samples fault_rd leaves them set. The next edge clears each bit whose condition is absent, and a bit whose condition is still present stays 1. Bits 7 and 4..0 always read 0.
- R11: irq_n goes low at the edge where any fault bit changes from 0 to 1. It stays low for exactly 256 cycles. A new bit rise during the pulse restarts the 256-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| vbus_mv | input | MV_W | Measured bus voltage, mV |
| vbat_mv | input | MV_W | Measured battery voltage, mV |
| vreg_mv | input | MV_W | Battery regulation setpoint, mV |
| ilim_prog_ma | input | ILIM_W | Programmed charge-current limit, mA |
| ocp_flag | input | 1 | System over-current comparator flag, synchronous |
| src_present | input | 1 | Input-source present flag, asynchronous |
| boost_en_stb | input | 1 | One-cycle host boost-enable strobe |
| fault_rd | input | 1 | One-cycle host fault-register read strobe |
| boost_on | output | 1 | Boost switching allowed |
| chg_en | output | 1 | Charging allowed |
| batsw_on | output | 1 | Battery switch closed |
| ilim_ma | output | ILIM_W | Charge-current limit in force, mA |
| fault_reg | output | 8 | Sticky fault register (bit 6 boost OV, bit 5 battery OV) |
| irq_n | output | 1 | Active-low host interrupt pulse |

## Verification
chg_en and ilim_ma are combinational. The bench drives inputs 1 ns after an edge and checks these two outputs 1 ns later, before any edge. boost_on, the fault bits and the start of irq_n are due after the first edge that samples the cause, so they are checked 1 ns after that edge. A read clears the fault bits only after the second edge, so the bench checks them after both the first and the second edge. Release of the battery switch is due after the third edge, so the bench checks that it is still open after the second edge and closed after the third. The interrupt width is measured by counting sampled low cycles from the setting edge onward.

// File: rtl/chg_fault_pkg.sv
package chg_fault_pkg;

    typedef enum logic [1:0] {
        BST_OFF  = 2'd0,
        BST_RUN  = 2'd1,
        BST_TRIP = 2'd2
    } boost_st_t;

    typedef enum logic {
        SW_CLOSED  = 1'b0,
        SW_LATCHED = 1'b1
    } batsw_st_t;

    typedef enum logic {
        IRQ_IDLE  = 1'b0,
        IRQ_PULSE = 1'b1
    } irq_st_t;

    localparam int FAULT_W    = 8;
    localparam int BOOST_BIT  = 6;
    localparam int BATOVP_BIT = 5;

    // setpoint plus about 4 percent: 41/1024 of the setpoint, floored
    function automatic logic [31:0] ovp_limit(input logic [31:0] set_mv);
        logic [31:0] frac;
        frac = (set_mv * 32'd41) >> 10;
        return set_mv + frac;
    endfunction

endpackage

// File: rtl/cfs_boost_ctl.sv
module cfs_boost_ctl
    import chg_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_stb,
    input  logic bus_over,
    output logic run,
    output logic trip_cond
);

    boost_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BST_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BST_OFF:  if (en_stb)   st_d = BST_RUN;
            BST_RUN:  if (bus_over) st_d = BST_TRIP;
            BST_TRIP: if (en_stb)   st_d = BST_RUN;
            default:                st_d = BST_OFF;
        endcase
    end

    always_comb begin
        run       = (st_q == BST_RUN);
        trip_cond = (st_q == BST_RUN) && bus_over;
    end

endmodule

// File: rtl/cfs_batsw_latch.sv
module cfs_batsw_latch
    import chg_fault_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ocp,
    input  logic src_async,
    output logic sw_closed
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   insert_evt;
    batsw_st_t              st_q, st_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= src_async;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], src_async};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign insert_evt = sync_q[SYNC_STAGES-1] & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SW_CLOSED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SW_CLOSED:  if (ocp)                st_d = SW_LATCHED;
            SW_LATCHED: if (insert_evt && !ocp) st_d = SW_CLOSED;
            default:                            st_d = SW_LATCHED;
        endcase
    end

    always_comb begin
        sw_closed = (st_q == SW_CLOSED);
    end

endmodule

// File: rtl/cfs_fault_reg.sv
module cfs_fault_reg
    import chg_fault_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int IRQ_LEN = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cond,
    input  logic             rd_stb,
    output logic [WIDTH-1:0] bits_q,
    output logic             irq_n
);

    localparam int CNT_W = $clog2(IRQ_LEN + 1);

    logic             rd_pend_q;
    logic [WIDTH-1:0] bits_d;
    logic             new_rise;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    irq_st_t          st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_pend_q <= 1'b0;
        else        rd_pend_q <= rd_stb;
    end

    // a pending read drops every bit whose condition has gone
    assign bits_d   = cond | (bits_q & ~{WIDTH{rd_pend_q}});
    assign new_rise = |(bits_d & ~bits_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            st_q   <= IRQ_IDLE;
            cnt_q  <= '0;
        end else begin
            bits_q <= bits_d;
            st_q   <= st_d;
            cnt_q  <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            IRQ_IDLE: begin
                if (new_rise) begin
                    st_d  = IRQ_PULSE;
                    cnt_d = CNT_W'(IRQ_LEN);
                end
            end
            IRQ_PULSE: begin
                if (new_rise) begin
                    cnt_d = CNT_W'(IRQ_LEN);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) st_d = IRQ_IDLE;
                end
            end
            default: st_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_n = (st_q != IRQ_PULSE);
    end

endmodule

// File: rtl/chg_fault_sup.sv
module chg_fault_sup
    import chg_fault_pkg::*;
#(
    parameter int MV_W         = 14,
    parameter int ILIM_W       = 12,
    parameter int BOOST_OVP_MV = 5300,
    parameter int SHORT_MV     = 2000,
    parameter int SAFE_MA      = 100,
    parameter int IRQ_LEN      = 256,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MV_W-1:0]    vbus_mv,
    input  logic [MV_W-1:0]    vbat_mv,
    input  logic [MV_W-1:0]    vreg_mv,
    input  logic [ILIM_W-1:0]  ilim_prog_ma,
    input  logic               ocp_flag,
    input  logic               src_present,
    input  logic               boost_en_stb,
    input  logic               fault_rd,
    output logic               boost_on,
    output logic               chg_en,
    output logic               batsw_on,
    output logic [ILIM_W-1:0]  ilim_ma,
    output logic [FAULT_W-1:0] fault_reg,
    output logic               irq_n
);

    logic               bus_over;
    logic               bat_over;
    logic               bat_short;
    logic [31:0]        bat_lim;
    logic               boost_trip;
    logic [FAULT_W-1:0] cond;

    // threshold comparators
    assign bus_over  = (32'(vbus_mv) > 32'(BOOST_OVP_MV));
    assign bat_lim   = ovp_limit(32'(vreg_mv));
    assign bat_over  = (32'(vbat_mv) > bat_lim);
    assign bat_short = (32'(vbat_mv) < 32'(SHORT_MV));

    // per-fault responses that act at once
    assign chg_en  = ~bat_over;
    assign ilim_ma = bat_short ? ILIM_W'(SAFE_MA) : ilim_prog_ma;

    cfs_boost_ctl u_boost (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_stb    (boost_en_stb),
        .bus_over  (bus_over),
        .run       (boost_on),
        .trip_cond (boost_trip)
    );

    cfs_batsw_latch #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_batsw (
        .clk       (clk),
        .rst_n     (rst_n),
        .ocp       (ocp_flag),
        .src_async (src_present),
        .sw_closed (batsw_on)
    );

    always_comb begin
        cond             = '0;
        cond[BOOST_BIT]  = boost_trip;
        cond[BATOVP_BIT] = bat_over;
    end

    cfs_fault_reg #(
        .WIDTH   (FAULT_W),
        .IRQ_LEN (IRQ_LEN)
    ) u_faults (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond   (cond),
        .rd_stb (fault_rd),
        .bits_q (fault_reg),
        .irq_n  (irq_n)
    );

endmodule

// File: rtl/chg_fault_sup_chk.sv
module chg_fault_sup_chk #(
    parameter int MV_W         = 14,
    parameter int BOOST_OVP_MV = 5300
) (
    input logic            clk,
    input logic            rst_n,
    input logic [MV_W-1:0] vbus_mv,
    input logic [MV_W-1:0] vbat_mv,
    input logic [MV_W-1:0] vreg_mv,
    input logic            ocp_flag,
    input logic            boost_en_stb,
    input logic            fault_rd,
    input logic            boost_on,
    input logic            chg_en,
    input logic            batsw_on,
    input logic [7:0]      fault_reg,
    input logic            irq_n
);

    logic        rd_seen_q;
    logic [31:0] lim_chk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_seen_q <= 1'b0;
        else        rd_seen_q <= fault_rd;
    end

    assign lim_chk = 32'(vreg_mv) + (32'(vreg_mv) * 32'd41) / 32'd1024;

    a_r2_boost_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_on && 32'(vbus_mv) > 32'(BOOST_OVP_MV)) |=> !boost_on);

    a_r3_rearm_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boost_on) |-> $past(boost_en_stb));

    a_r4_bit6_set: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_on && 32'(vbus_mv) > 32'(BOOST_OVP_MV)) |=> fault_reg[6]);

    a_r5_charge_block: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(vbat_mv) > lim_chk) |-> !chg_en);

    a_r6_bit5_set: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(vbat_mv) > lim_chk) |=> fault_reg[5]);

    a_r8_open_on_ocp: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(batsw_on) |-> $past(ocp_flag));

    a_r10_sticky_bit5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_reg[5] && !rd_seen_q) |=> fault_reg[5]);

    a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($countones(fault_reg & ~$past(fault_reg)) != 0));

endmodule

bind chg_fault_sup chg_fault_sup_chk #(
    .MV_W         (MV_W),
    .BOOST_OVP_MV (BOOST_OVP_MV)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vbus_mv      (vbus_mv),
    .vbat_mv      (vbat_mv),
    .vreg_mv      (vreg_mv),
    .ocp_flag     (ocp_flag),
    .boost_en_stb (boost_en_stb),
    .fault_rd     (fault_rd),
    .boost_on     (boost_on),
    .chg_en       (chg_en),
    .batsw_on     (batsw_on),
    .fault_reg    (fault_reg),
    .irq_n        (irq_n)
);

// File: tb/chg_fault_sup_bench.sv
`timescale 1ns/1ps
module chg_fault_sup_bench;

    localparam int MV_W   = 14;
    localparam int ILIM_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MV_W-1:0]   vbus_mv = 14'd5000;
    logic [MV_W-1:0]   vbat_mv = 14'd3700;
    logic [MV_W-1:0]   vreg_mv = 14'd4200;
    logic [ILIM_W-1:0] ilim_prog_ma = 12'd1500;
    logic              ocp_flag = 1'b0;
    logic              src_present = 1'b0;
    logic              boost_en_stb = 1'b0;
    logic              fault_rd = 1'b0;
    logic              boost_on, chg_en, batsw_on, irq_n;
    logic [ILIM_W-1:0] ilim_ma;
    logic [7:0]        fault_reg;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    chg_fault_sup u_chg_fault_sup (
        .clk          (clk),
        .rst_n        (rst_n),
        .vbus_mv      (vbus_mv),
        .vbat_mv      (vbat_mv),
        .vreg_mv      (vreg_mv),
        .ilim_prog_ma (ilim_prog_ma),
        .ocp_flag     (ocp_flag),
        .src_present  (src_present),
        .boost_en_stb (boost_en_stb),
        .fault_rd     (fault_rd),
        .boost_on     (boost_on),
        .chg_en       (chg_en),
        .batsw_on     (batsw_on),
        .ilim_ma      (ilim_ma),
        .fault_reg    (fault_reg),
        .irq_n        (irq_n)
    );

    function automatic bit exp_bat_over(int vbat, int vreg);
        return vbat > (vreg + (vreg * 41) / 1024);
    endfunction

    function automatic int exp_ilim(int vbat, int prog);
        return (vbat < 2000) ? 100 : prog;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic count_irq_low(input string req);
        int n;
        n = 1;
        while (n < 1000) begin
            tick();
            if (irq_n) break;
            n++;
        end
        chk(n == 256, req, n, 256);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit exp5;
        void'($urandom(32'd20240611));
        ticks(4);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(fault_reg == 8'h00, "R1 fault_reg", fault_reg, 0);
        chk(boost_on == 1'b0, "R1 boost_on", boost_on, 0);
        chk(chg_en == 1'b1, "R1 chg_en", chg_en, 1);
        chk(batsw_on == 1'b1, "R1 batsw_on", batsw_on, 1);
        chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);

        // R2 boost start and boundary
        boost_en_stb = 1'b1;
        tick();
        boost_en_stb = 1'b0;
        chk(boost_on == 1'b1, "R2 boost start", boost_on, 1);
        vbus_mv = 14'd5300;
        tick();
        chk(boost_on == 1'b1, "R2 5300 no trip", boost_on, 1);
        chk(fault_reg[6] == 1'b0, "R4 no bit6 at 5300", fault_reg[6], 0);
        vbus_mv = 14'd5301;
        tick();
        chk(boost_on == 1'b0, "R2 trip above 5300", boost_on, 0);
        chk(fault_reg[6] == 1'b1, "R4 bit6 set", fault_reg[6], 1);
        chk(irq_n == 1'b0, "R11 irq start", irq_n, 0);
        count_irq_low("R11 pulse width");

        // R3 stays off until fresh strobe
        vbus_mv = 14'd5000;
        ticks(5);
        chk(boost_on == 1'b0, "R3 stays off", boost_on, 0);
        boost_en_stb = 1'b1;
        tick();
        boost_en_stb = 1'b0;
        chk(boost_on == 1'b1, "R3 rearm", boost_on, 1);

        // R10 read clear of bit6
        fault_rd = 1'b1;
        tick();
        fault_rd = 1'b0;
        chk(fault_reg[6] == 1'b1, "R10 held at read edge", fault_reg[6], 1);
        tick();
        chk(fault_reg[6] == 1'b0, "R10 cleared next edge", fault_reg[6], 0);
        chk((fault_reg & 8'h9F) == 8'h00, "R10 unused bits", fault_reg, 0);

        // R5 / R6 battery over-voltage, threshold 4200 -> 4368
        vbat_mv = 14'd4368;
        #1;
        chk(chg_en == 1'b1, "R5 at threshold", chg_en, 1);
        vbat_mv = 14'd4369;
        #1;
        chk(chg_en == 1'b0, "R5 immediate block", chg_en, 0);
        tick();
        chk(fault_reg[5] == 1'b1, "R6 bit5 set", fault_reg[5], 1);
        fault_rd = 1'b1;
        tick();
        fault_rd = 1'b0;
        tick();
        chk(fault_reg[5] == 1'b1, "R10 kept while present", fault_reg[5], 1);
        vbat_mv = 14'd3800;
        #1;
        chk(chg_en == 1'b1, "R5 recover", chg_en, 1);
        fault_rd = 1'b1;
        tick();
        fault_rd = 1'b0;
        tick();
        chk(fault_reg[5] == 1'b0, "R10 bit5 cleared", fault_reg[5], 0);

        // R7 current limit boundary
        vbat_mv = 14'd1999;
        #1;
        chk(ilim_ma == 12'd100, "R7 below 2000", ilim_ma, 100);
        vbat_mv = 14'd2000;
        #1;
        chk(ilim_ma == ilim_prog_ma, "R7 at 2000", ilim_ma, ilim_prog_ma);
        vbat_mv = 14'd3800;

        // R11 restart during pulse
        ticks(300);
        vbat_mv = 14'd4400;
        tick();
        vbat_mv = 14'd3800;
        chk(irq_n == 1'b0, "R11 bit5 pulse", irq_n, 0);
        ticks(100);
        vbus_mv = 14'd5400;
        tick();
        vbus_mv = 14'd5000;
        chk(fault_reg[6] == 1'b1, "R4 second trip", fault_reg[6], 1);
        count_irq_low("R11 restart width");
        fault_rd = 1'b1;
        tick();
        fault_rd = 1'b0;
        tick();

        // R8 / R9 battery switch latch
        ocp_flag = 1'b1;
        tick();
        chk(batsw_on == 1'b0, "R8 latch on ocp", batsw_on, 0);
        ocp_flag = 1'b0;
        ticks(5);
        chk(batsw_on == 1'b0, "R8 stays latched", batsw_on, 0);
        src_present = 1'b1;
        ticks(2);
        chk(batsw_on == 1'b0, "R9 not before third edge", batsw_on, 0);
        tick();
        chk(batsw_on == 1'b1, "R9 release on insertion", batsw_on, 1);
        ocp_flag = 1'b1;
        tick();
        ocp_flag = 1'b0;
        ticks(10);
        chk(batsw_on == 1'b0, "R9 level does not release", batsw_on, 0);
        src_present = 1'b0;
        ticks(4);
        ocp_flag = 1'b1;
        src_present = 1'b1;
        ticks(5);
        chk(batsw_on == 1'b0, "R9 ocp blocks release", batsw_on, 0);
        ocp_flag = 1'b0;
        src_present = 1'b0;
        ticks(4);
        src_present = 1'b1;
        ticks(3);
        chk(batsw_on == 1'b1, "R9 second release", batsw_on, 1);

        // random sweep, R5 R6 R7
        exp5 = fault_reg[5];
        for (int k = 0; k < 400; k++) begin
            int vr, vb, pg;
            vr = 3500 + int'($urandom % 901);
            if (($urandom % 4) == 0) vb = int'($urandom % 4600);
            else vb = vr + int'($urandom % 401) - 200;
            pg = int'($urandom % 4096);
            vreg_mv = MV_W'(vr);
            vbat_mv = MV_W'(vb);
            ilim_prog_ma = ILIM_W'(pg);
            #1;
            chk(chg_en == !exp_bat_over(vb, vr), "R5 random", chg_en, !exp_bat_over(vb, vr));
            chk(int'(ilim_ma) == exp_ilim(vb, pg), "R7 random", ilim_ma, exp_ilim(vb, pg));
            exp5 = exp5 | exp_bat_over(vb, vr);
            tick();
            chk(fault_reg[5] == exp5, "R6 random", fault_reg[5], exp5);
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule